// File: doc/BRIEF.md
# Accumulator ALU with Registered Condition Flags

This block is the arithmetic and logic engine of a small 8-bit processor core. It is combinational from its operand inputs to its result. The accumulator value and a second operand come in, together with a five-bit operation code. The result leaves in the same cycle. The caller writes the result back into its accumulator when the operation is one that changes the accumulator.

Five condition flags are held in a register inside the block: sign, zero, auxiliary carry, parity and carry. An operation marked valid updates, on the next clock edge, only the flags that it is defined to affect, and the others keep their value. The stored carry feeds the carry-using operations: add with carry, subtract with borrow, the rotates through carry, complement carry and decimal adjust. The stored auxiliary carry also feeds decimal adjust.

Top module: `acc_alu`

## Requirements
- R1: After reset all five flags are 0. In a cycle with `op_valid` low, the flags keep their value at the next edge. The flag vector is laid out as bit 4 sign, bit 3 zero, bit 2 auxiliary carry, bit 1 parity, bit 0 carry.
- R2: Add (code 0) gives A+B, and add-with-carry (code 1) gives A+B+stored carry, both modulo 256. Carry is the carry out of bit 7. Auxiliary carry is the carry out of bit 3.
- R3: Subtract (code 2) gives A-B, and subtract-with-borrow (code 3) gives A-B-stored carry, modulo 256. Carry is set when B plus the borrow-in exceeds A as unsigned values. Auxiliary carry is the carry out of bit 3 when A, the inverse of B and the inverted borrow-in are added.
- R4: Every operation that updates sign, zero and parity (codes 0–9 and 17) sets them from its byte outcome. Sign is bit 7. Zero is set when the byte equals 0x00. Parity is 1 when the count of 1 bits is even.
- R5: AND (code 4), XOR (code 5) and OR (code 6) return the bitwise result. AND sets auxiliary carry to 1 and carry to 0. XOR and OR clear both.
- R6: Compare (code 7) returns A unchanged on `result` and sets the flags from A-B. If A<B, carry is 1 and zero is 0. If A=B, carry is 0 and zero is 1. If A>B, both are 0.
- R7: Increment (code 8) and decrement (code 9) return A+1 and A-1 modulo 256. They update every flag except carry, which keeps its value. For decrement, auxiliary carry is set when the low nibble of A is nonzero.
- R8: Complement (code 10) returns the bitwise inverse of A and changes no flag.
- R9: The rotates change only carry. Rotate-left-circular (code 11) copies bit 7 into carry and into bit 0. Rotate-right-circular (code 12) copies bit 0 into carry and into bit 7. Rotate-left-through-carry (code 13) moves the old carry into bit 0 and bit 7 into carry. Rotate-right-through-carry (code 14) moves the old carry into bit 7 and bit 0 into carry.
- R10: Set carry (code 15) forces carry to 1. Complement carry (code 16) inverts carry. Both return A and leave the other flags unchanged.
- R11: Decimal adjust (code 17) adds 0x06 when the low nibble of A exceeds 9 or the stored auxiliary carry is 1. It adds 0x60 when the high nibble exceeds 9 or the stored carry is 1. Carry becomes 1 when the 0x60 correction is applied and otherwise keeps its value. Auxiliary carry is the carry out of bit 3 of the correction add. For example, 0x99+0x79 followed by decimal adjust gives 0x78 with carry 1.
- R12: Codes 18 to 31 return A and change no flag, even when `op_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flags update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears the flags |
| op_valid | input | 1 | The operation on `op` is committed to the flags at the next edge |
| op | input | 5 | Operation code (see requirements) |
| acc | input | 8 | Accumulator operand A |
| opnd | input | 8 | Second operand B |
| result | output | 8 | Combinational operation result |
| flags | output | 5 | Stored flags {sign, zero, aux, parity, carry} |

## Verification
The checker properties assume that `op`, `acc` and `opnd` are stable and known around each rising edge, so that the inputs sampled at the edge are the ones that produced the flag update. The bench changes every input only at the falling edge and holds it there until the next falling edge. The properties accept any operation code, including codes 18–31. The stimulus therefore covers the whole 5-bit space: it drops `op_valid` at random and mixes directed sequences into the random ones, so that the carry and auxiliary-carry inputs reach both values before each carry-consuming operation.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DW = 8;
    localparam int NW = 4;

    typedef enum logic [4:0] {
        OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3,
        OP_AND = 5'd4,  OP_XOR = 5'd5,  OP_OR  = 5'd6,  OP_CMP = 5'd7,
        OP_INC = 5'd8,  OP_DEC = 5'd9,  OP_CPL = 5'd10, OP_RLC = 5'd11,
        OP_RRC = 5'd12, OP_RAL = 5'd13, OP_RAR = 5'd14, OP_STC = 5'd15,
        OP_CMC = 5'd16, OP_DAA = 5'd17
    } alu_op_e;

    typedef struct packed {
        logic sign;
        logic zero;
        logic aux;
        logic par;
        logic cy;
    } flags_t;
endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
    parameter int W  = 8,
    parameter int NW = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         ci,
    output logic [W-1:0] sum,
    output logic         c_half,
    output logic         c_full
);
    localparam int HW = W - NW;

    logic [NW:0] lo;
    logic [HW:0] hi;

    always_comb begin
        lo     = {1'b0, x[NW-1:0]} + {1'b0, y[NW-1:0]} + {{NW{1'b0}}, ci};
        hi     = {1'b0, x[W-1:NW]} + {1'b0, y[W-1:NW]} + {{HW{1'b0}}, lo[NW]};
        sum    = {hi[HW-1:0], lo[NW-1:0]};
        c_half = lo[NW];
        c_full = hi[HW];
    end
endmodule

// File: rtl/alu8_szp.sv
module alu8_szp #(
    parameter int W = 8
) (
    input  logic [W-1:0] v,
    output logic         sign,
    output logic         zero,
    output logic         par
);
    always_comb begin
        sign = v[W-1];
        zero = (v == '0);
        par  = ~^v;
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W  = DW,
    parameter int NH = NW
) (
    input  logic [4:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cy_in,
    input  logic         ac_in,
    output logic [W-1:0] res,
    output flags_t       f_new,
    output flags_t       f_upd
);
    localparam int HW = W - NH;

    logic [W-1:0] add_y;
    logic         add_ci;
    logic [W-1:0] sum;
    logic         c_half;
    logic         c_full;
    logic         lo_fix;
    logic         hi_fix;
    logic [W-1:0] corr;
    logic [W-1:0] szp_src;
    logic         s_bit;
    logic         z_bit;
    logic         p_bit;

    // operand selection for the shared adder
    always_comb begin
        lo_fix = (a[NH-1:0] > NH'(9)) | ac_in;
        hi_fix = (a[W-1:NH] > HW'(9)) | cy_in;
        corr   = {(hi_fix ? HW'(6) : HW'(0)), (lo_fix ? NH'(6) : NH'(0))};
        add_y  = b;
        add_ci = 1'b0;
        case (op)
            OP_ADC:         add_ci = cy_in;
            OP_SUB, OP_CMP: begin add_y = ~b; add_ci = 1'b1; end
            OP_SBB:         begin add_y = ~b; add_ci = ~cy_in; end
            OP_INC:         begin add_y = '0; add_ci = 1'b1; end
            OP_DEC:         add_y = '1;
            OP_DAA:         add_y = corr;
            default:        ;
        endcase
    end

    alu8_adder #(.W(W), .NW(NH)) u_add (
        .x      (a),
        .y      (add_y),
        .ci     (add_ci),
        .sum    (sum),
        .c_half (c_half),
        .c_full (c_full)
    );

    // result selection
    always_comb begin
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB,
            OP_INC, OP_DEC, OP_DAA: res = sum;
            OP_AND:  res = a & b;
            OP_XOR:  res = a ^ b;
            OP_OR:   res = a | b;
            OP_CPL:  res = ~a;
            OP_RLC:  res = {a[W-2:0], a[W-1]};
            OP_RRC:  res = {a[0], a[W-1:1]};
            OP_RAL:  res = {a[W-2:0], cy_in};
            OP_RAR:  res = {cy_in, a[W-1:1]};
            default: res = a;
        endcase
        szp_src = (op == OP_CMP) ? sum : res;
    end

    alu8_szp #(.W(W)) u_szp (
        .v    (szp_src),
        .sign (s_bit),
        .zero (z_bit),
        .par  (p_bit)
    );

    // new flag values and per-operation update mask
    always_comb begin
        f_new      = '0;
        f_upd      = '0;
        f_new.sign = s_bit;
        f_new.zero = z_bit;
        f_new.par  = p_bit;
        f_new.aux  = c_half;
        case (op)
            OP_ADD, OP_ADC: begin f_new.cy = c_full;  f_upd = '1; end
            OP_SUB, OP_SBB,
            OP_CMP:         begin f_new.cy = ~c_full; f_upd = '1; end
            OP_AND:         begin f_new.aux = 1'b1; f_new.cy = 1'b0; f_upd = '1; end
            OP_XOR, OP_OR:  begin f_new.aux = 1'b0; f_new.cy = 1'b0; f_upd = '1; end
            OP_INC, OP_DEC: begin f_upd = '1; f_upd.cy = 1'b0; end
            OP_RLC, OP_RAL: begin f_new.cy = a[W-1]; f_upd.cy = 1'b1; end
            OP_RRC, OP_RAR: begin f_new.cy = a[0];   f_upd.cy = 1'b1; end
            OP_STC:         begin f_new.cy = 1'b1;   f_upd.cy = 1'b1; end
            OP_CMC:         begin f_new.cy = ~cy_in; f_upd.cy = 1'b1; end
            OP_DAA:         begin f_new.cy = cy_in | hi_fix; f_upd = '1; end
            default:        ;
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import alu8_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [4:0]   op,
    input  logic [W-1:0] acc,
    input  logic [W-1:0] opnd,
    output logic [W-1:0] result,
    output logic [4:0]   flags
);
    typedef struct packed {
        flags_t fl;
    } state_t;

    state_t state_d;
    state_t state_q;
    flags_t f_new;
    flags_t f_upd;

    alu8_core #(.W(W), .NH(NW)) u_core (
        .op    (op),
        .a     (acc),
        .b     (opnd),
        .cy_in (state_q.fl.cy),
        .ac_in (state_q.fl.aux),
        .res   (result),
        .f_new (f_new),
        .f_upd (f_upd)
    );

    always_comb begin
        state_d = state_q;
        if (op_valid) begin
            state_d.fl = flags_t'((f_new & f_upd) | (state_q.fl & ~f_upd));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flags = state_q.fl;
endmodule

// File: rtl/alu8_checker.sv
module alu8_checker
    import alu8_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid,
    input logic [4:0] op,
    input logic [7:0] acc,
    input logic [7:0] opnd,
    input logic [7:0] result,
    input logic [4:0] flags
);
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(flags));

    a_r6_cmp_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CMP) |-> (result == acc));

    a_r6_cmp_borrow: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_CMP) |=> (flags[0] == $past(acc < opnd)));

    a_r7_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op == OP_INC || op == OP_DEC)) |=> (flags[0] == $past(flags[0])));

    a_r8_cpl_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_CPL) |=> $stable(flags));

    a_r10_stc_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_STC) |=> flags[0]);

    a_r4_logic_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op == OP_AND || op == OP_OR || op == OP_XOR))
        |=> (flags[3] == ($past(result) == 8'h00)));

    a_r12_unused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op > OP_DAA) |=> $stable(flags));
endmodule

bind acc_alu alu8_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op       (op),
    .acc      (acc),
    .opnd     (opnd),
    .result   (result),
    .flags    (flags)
);

// File: tb/acc_alu_test.sv
`timescale 1ns/1ps
module acc_alu_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [4:0] op = '0;
    logic [7:0] acc = '0;
    logic [7:0] opnd = '0;
    wire  [7:0] result;
    wire  [4:0] flags;

    int         checks = 0;
    int         errors = 0;
    logic [4:0] mf = '0;
    string      prev_tag = "R1";
    bit         prev_szp = 1'b0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    acc_alu uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op),
        .acc(acc), .opnd(opnd), .result(result), .flags(flags)
    );

    function automatic int ones(int v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += (v >> i) & 1;
        return n;
    endfunction

    function automatic string tag_of(int o);
        case (o)
            0, 1:           return "R2";
            2, 3:           return "R3";
            4, 5, 6:        return "R5";
            7:              return "R6";
            8, 9:           return "R7";
            10:             return "R8";
            11, 12, 13, 14: return "R9";
            15, 16:         return "R10";
            17:             return "R11";
            default:        return "R12";
        endcase
    endfunction

    // behavioural reference: integer arithmetic on the operands
    task automatic model(input int o, input int a, input int b, input logic [4:0] f,
                         output int r, output logic [4:0] nf);
        int  cy, ac, s, bin, corr, v;
        bit  upd_szp, lo, hi;
        cy = int'(f[0]); ac = int'(f[2]);
        nf = f; r = a; v = 0; upd_szp = 1'b0;
        case (o)
            0, 1: begin
                bin = (o == 1) ? cy : 0;
                s = a + b + bin; r = s & 255; v = r; upd_szp = 1'b1;
                nf[2] = ((a & 15) + (b & 15) + bin) > 15; nf[0] = s > 255;
            end
            2, 3, 7: begin
                bin = (o == 3) ? cy : 0;
                s = a - b - bin; v = s & 255; upd_szp = 1'b1;
                r = (o == 7) ? a : v;
                nf[2] = ((a & 15) + ((~b) & 15) + (1 - bin)) > 15; nf[0] = s < 0;
            end
            4: begin r = a & b; v = r; upd_szp = 1'b1; nf[2] = 1'b1; nf[0] = 1'b0; end
            5: begin r = a ^ b; v = r; upd_szp = 1'b1; nf[2] = 1'b0; nf[0] = 1'b0; end
            6: begin r = a | b; v = r; upd_szp = 1'b1; nf[2] = 1'b0; nf[0] = 1'b0; end
            8: begin r = (a + 1) & 255; v = r; upd_szp = 1'b1; nf[2] = (a & 15) == 15; end
            9: begin r = (a + 255) & 255; v = r; upd_szp = 1'b1; nf[2] = (a & 15) != 0; end
            10: r = (~a) & 255;
            11: begin nf[0] = a[7]; r = ((a << 1) | (a >> 7)) & 255; end
            12: begin nf[0] = a[0]; r = (a >> 1) | ((a & 1) << 7); end
            13: begin nf[0] = a[7]; r = ((a << 1) | cy) & 255; end
            14: begin nf[0] = a[0]; r = (a >> 1) | (cy << 7); end
            15: nf[0] = 1'b1;
            16: nf[0] = ~f[0];
            17: begin
                lo = ((a & 15) > 9) || (ac != 0);
                hi = ((a >> 4) > 9) || (cy != 0);
                corr = (lo ? 6 : 0) + (hi ? 96 : 0);
                r = (a + corr) & 255; v = r; upd_szp = 1'b1;
                nf[2] = ((a & 15) + (corr & 15)) > 15;
                nf[0] = (cy != 0) || hi;
            end
            default: ;
        endcase
        if (upd_szp) begin
            nf[4] = v[7];
            nf[3] = (v == 0);
            nf[1] = (ones(v) % 2) == 0;
        end
    endtask

    task automatic chk(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(bit v, int o, int a, int b);
        int         r;
        logic [4:0] nf;
        @(negedge clk);
        chk(prev_tag, int'(flags), int'(mf), "flags");
        if (prev_szp)
            chk("R4", int'({flags[4:3], flags[1]}), int'({mf[4:3], mf[1]}), "sign/zero/parity");
        op_valid = v; op = o[4:0]; acc = a[7:0]; opnd = b[7:0];
        #1;
        model(o, a, b, mf, r, nf);
        chk(tag_of(o), int'(result), r, "result");
        if (v) begin
            mf = nf; prev_tag = tag_of(o);
            prev_szp = (o <= 9) || (o == 17);
        end else begin
            prev_tag = "R1"; prev_szp = 1'b0;
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1", int'(flags), 0, "reset flags");
        // R2 then R11: BCD 99 + 79 -> 78 with carry
        step(1, 0, 'h99, 'h79);
        step(1, 17, 'h12, 0);
        // R6 compare: less, equal, greater
        step(1, 7, 5, 9);
        step(1, 7, 9, 9);
        step(1, 7, 9, 5);
        // R10 then R7: increment wraps to zero, carry stays
        step(1, 15, 'h33, 0);
        step(1, 8, 'hFF, 0);
        step(1, 16, 'h33, 0);
        step(1, 9, 'h00, 0);
        // R9 rotates
        step(1, 11, 'h81, 0);
        step(1, 13, 'h80, 0);
        step(1, 14, 'h01, 0);
        step(1, 12, 'h01, 0);
        // R5, R8, R3, R12, R1
        step(1, 4, 'hF0, 'h3C);
        step(1, 10, 'h5A, 0);
        step(1, 15, 0, 0);
        step(1, 3, 'h10, 'h10);
        step(1, 20, 'h44, 'h12);
        step(0, 15, 'h44, 'h12);
        step(1, 6, 0, 0);
        step(1, 17, 'h9A, 0);
        for (int i = 0; i < 3000; i++) begin
            step($urandom_range(0, 9) != 0, $urandom_range(0, 31),
                 $urandom_range(0, 255), $urandom_range(0, 255));
        end
        step(0, 0, 0, 0);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end
endmodule